// File: doc/BRIEF.md
# Handshake Parallel Port

This block is one bidirectional parallel port of parameterised width with two peripheral control lines. Each bit has its own direction bit: an output bit drives the pin from the output register, and an input bit leaves the pin undriven and reads back its level. The pins leave the block as a data vector and an output-enable vector. A two-bit register select chooses one of four targets. These are the port data, the direction register, a second data address that bypasses the handshake logic, and a five-bit control field.

Control line one is always an input, and its active edge is selectable. Control line two has eight modes. It can be an edge-sensitive input whose flag a port access clears, or an independent interrupt input whose flag only an explicit clear removes. It can also be a handshake output, a one-cycle strobe, or a fixed level. An active edge on line one can capture the pin levels into an input latch. The block keeps one flag per control line, reports each flag set as a one-cycle pulse, and accepts a clear strobe per flag. Interrupt enabling and priority belong to the logic that consumes those pulses and flags.

Top module: `hsk_port`

## Requirements
- R1: Register select 0 is the port data, 1 the direction register, 2 the data alias and 3 the control field. A write to 0 or 2 loads the output register. A direction bit of 1 sets that bit of `pinOe` and drives it from the output register. A data read returns the output register for output bits and the input value for input bits, and `rdData` is zero when `selValid` is low.
- R2: Control bit 0 picks the active edge of `c1In`: 0 for falling, 1 for rising. An active edge sets `c1Flag` and gives a one-cycle `c1Set` pulse on the next clock; the opposite edge does nothing.
- R3: Control bits 3:1 hold the line-two mode. Code 000 is a falling-edge input, 010 a rising-edge input, 001 an independent falling-edge input and 011 an independent rising-edge input. In these modes an active `c2In` edge sets `c2Flag` and pulses `c2Set`. Codes 1xx never set the flag.
- R4: In mode 100, an access at select 0 (read or write) drives `c2Out` low from the next cycle. It stays low until an active `c1In` edge returns it high.
- R5: In mode 101, each access at select 0 drives `c2Out` low for exactly one cycle, after which it returns high.
- R6: `c2Oe` is high exactly in modes 1xx. Mode 110 holds `c2Out` low and mode 111 holds it high.
- R7: When control bit 4 is 1, an active `c1In` edge captures `pinIn` into the input latch. Data reads then return the latched value for input bits until the next active edge.
- R8: An access at select 2 produces no `c2Out` action and clears no flag.
- R9: An access at select 0 clears `c1Flag`, and clears `c2Flag` in modes 000 and 010 but not in 001 or 011. `flagClr[0]` and `flagClr[1]` clear the two flags. A set and a clear in the same cycle leave the flag set.
- R10: Reset clears the output, direction and control registers, makes every pin an input, clears both flags and leaves line two in mode 000 with `c2Oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selValid | input | 1 | Register access this cycle |
| selWrite | input | 1 | 1 for write, 0 for read |
| selAddr | input | 2 | Register select |
| wrData | input | WIDTH | Write data |
| rdData | output | WIDTH | Read data, combinational |
| pinIn | input | WIDTH | Pin levels seen by the port |
| pinOut | output | WIDTH | Pin drive values |
| pinOe | output | WIDTH | Per-pin output enable |
| c1In | input | 1 | Control line one |
| c2In | input | 1 | Control line two input level |
| c2Out | output | 1 | Control line two drive value |
| c2Oe | output | 1 | Control line two output enable |
| flagClr | input | 2 | Clear strobes, bit 0 line one, bit 1 line two |
| c1Flag | output | 1 | Line-one flag |
| c2Flag | output | 1 | Line-two flag |
| c1Set | output | 1 | One-cycle pulse when line-one flag sets |
| c2Set | output | 1 | One-cycle pulse when line-two flag sets |

## Verification
The bench builds the block at its default width of 8. That width holds the whole five-bit control field, so every one of the eight line-two modes, both edge polarities and the latch enable can be written and read back. A random phase then writes arbitrary control values. Those writes cross mode switches with active edges, flag clears and handshake accesses in the same cycle, and each cycle is compared with the behavioural reference model.

// File: rtl/hsk_port_pkg.sv
`timescale 1ns/1ps
package hsk_port_pkg;

  // line-two operating modes; bit 2 marks the output modes
  typedef enum logic [2:0] {
    C2_IN_FALL  = 3'b000,
    C2_IRQ_FALL = 3'b001,
    C2_IN_RISE  = 3'b010,
    C2_IRQ_RISE = 3'b011,
    C2_HSHAKE   = 3'b100,
    C2_PULSE    = 3'b101,
    C2_LOW      = 3'b110,
    C2_HIGH     = 3'b111
  } c2Mode_e;

  // control field: bit 4 latch enable, bits 3:1 line-two mode, bit 0 line-one polarity
  typedef struct packed {
    logic    latchEn;
    c2Mode_e c2Mode;
    logic    c1Rise;
  } portCfg_t;

  localparam int CFG_W = $bits(portCfg_t);

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_ALIAS = 2'd2,
    SEL_CFG   = 2'd3
  } portSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/hsk_port_edge.sv
`timescale 1ns/1ps
module hsk_port_edge (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic riseSel,
  input  logic enable,
  output logic hit
);

  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= lineIn;
  end

  always_comb begin
    if (!enable)      hit = 1'b0;
    else if (riseSel) hit = lineIn & ~prevQ;
    else              hit = ~lineIn & prevQ;
  end

endmodule

// File: rtl/hsk_port_ctrl.sv
`timescale 1ns/1ps
module hsk_port_ctrl
  import hsk_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selValid,
  input  logic             selWrite,
  input  logic [1:0]       selAddr,
  input  logic [CFG_W-1:0] wrCfg,
  input  logic             c1In,
  input  logic             c2In,
  input  logic [1:0]       flagClr,
  output portCfg_t         cfg,
  output dpStrobe_t        strobe,
  output logic             c2Out,
  output logic             c2Oe,
  output logic             c1Flag,
  output logic             c2Flag,
  output logic             c1Set,
  output logic             c2Set
);

  logic hsAccess, aliasAccess, cfgWr;
  logic c1Hit, c2Hit;
  logic c2IsInput, c2Indep;
  logic c2HsQ;

  assign hsAccess    = selValid && (selAddr == SEL_DATA);
  assign aliasAccess = selValid && (selAddr == SEL_ALIAS);
  assign cfgWr       = selValid && selWrite && (selAddr == SEL_CFG);

  assign c2IsInput = ~cfg.c2Mode[2];
  assign c2Indep   = c2IsInput & cfg.c2Mode[0];

  hsk_port_edge u_c1Edge (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (c1In),
    .riseSel (cfg.c1Rise),
    .enable  (1'b1),
    .hit     (c1Hit)
  );

  hsk_port_edge u_c2Edge (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (c2In),
    .riseSel (cfg.c2Mode[1]),
    .enable  (c2IsInput),
    .hit     (c2Hit)
  );

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWr) cfg <= portCfg_t'(wrCfg);
  end

  // flags and set pulses; a set beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c1Flag <= 1'b0;
      c2Flag <= 1'b0;
      c1Set  <= 1'b0;
      c2Set  <= 1'b0;
    end else begin
      c1Set <= c1Hit;
      c2Set <= c2Hit;
      if (c1Hit)                        c1Flag <= 1'b1;
      else if (hsAccess || flagClr[0])  c1Flag <= 1'b0;
      if (c2Hit)                        c2Flag <= 1'b1;
      else if (flagClr[1] || (hsAccess && c2IsInput && !c2Indep))
                                        c2Flag <= 1'b0;
    end
  end

  // line-two handshake / strobe state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) c2HsQ <= 1'b1;
    else begin
      unique case (cfg.c2Mode)
        C2_HSHAKE: begin
          if (hsAccess)   c2HsQ <= 1'b0;
          else if (c1Hit) c2HsQ <= 1'b1;
        end
        C2_PULSE: c2HsQ <= ~hsAccess;
        default:  c2HsQ <= 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (cfg.c2Mode)
      C2_LOW:  c2Out = 1'b0;
      C2_HIGH: c2Out = 1'b1;
      default: c2Out = c2HsQ;
    endcase
  end

  assign c2Oe = cfg.c2Mode[2];

  always_comb begin
    strobe.wrData  = selValid && selWrite &&
                     ((selAddr == SEL_DATA) || (selAddr == SEL_ALIAS));
    strobe.wrDir   = selValid && selWrite && (selAddr == SEL_DIR);
    strobe.capture = c1Hit && cfg.latchEn;
  end

  AST_C1_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    c1Hit |=> (c1Flag && c1Set));  // R2

  AST_HS_ASSERT: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.c2Mode == C2_HSHAKE && hsAccess) |=> !c2Out);  // R4

  AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.c2Mode == C2_PULSE && !hsAccess && !cfgWr) |=> c2Out);  // R5

  AST_ALIAS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.c2Mode == C2_HSHAKE && aliasAccess && c2Out) |=> c2Out);  // R8

  AST_INDEP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (c2Indep && hsAccess && !flagClr[1] && !c2Hit) |=> $stable(c2Flag));  // R9

endmodule

// File: rtl/hsk_port_dp.sv
`timescale 1ns/1ps
module hsk_port_dp
  import hsk_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  portCfg_t         cfg,
  input  logic             selValid,
  input  logic [1:0]       selAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] rdData
);

  localparam int PAD = WIDTH - CFG_W;

  logic [WIDTH-1:0] outQ, dirQ, latQ, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
      dirQ <= '0;
      latQ <= '0;
    end else begin
      if (strobe.wrData)  outQ <= wrData;
      if (strobe.wrDir)   dirQ <= wrData;
      if (strobe.capture) latQ <= pinIn;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign portView[i] = dirQ[i] ? outQ[i] : (cfg.latchEn ? latQ[i] : pinIn[i]);
  end

  always_comb begin
    rdData = '0;
    if (selValid) begin
      unique case (selAddr)
        SEL_DATA, SEL_ALIAS: rdData = portView;
        SEL_DIR:             rdData = dirQ;
        default:             rdData = {{PAD{1'b0}}, cfg};
      endcase
    end
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ;

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> (pinOut == $past(wrData)));  // R1

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (latQ == $past(pinIn)));  // R7

endmodule

// File: rtl/hsk_port.sv
`timescale 1ns/1ps
module hsk_port
  import hsk_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selValid,
  input  logic             selWrite,
  input  logic [1:0]       selAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic             c1In,
  input  logic             c2In,
  output logic             c2Out,
  output logic             c2Oe,
  input  logic [1:0]       flagClr,
  output logic             c1Flag,
  output logic             c2Flag,
  output logic             c1Set,
  output logic             c2Set
);

  portCfg_t  cfg;
  dpStrobe_t strobe;

  hsk_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selValid (selValid),
    .selWrite (selWrite),
    .selAddr  (selAddr),
    .wrCfg    (wrData[CFG_W-1:0]),
    .c1In     (c1In),
    .c2In     (c2In),
    .flagClr  (flagClr),
    .cfg      (cfg),
    .strobe   (strobe),
    .c2Out    (c2Out),
    .c2Oe     (c2Oe),
    .c1Flag   (c1Flag),
    .c2Flag   (c2Flag),
    .c1Set    (c1Set),
    .c2Set    (c2Set)
  );

  hsk_port_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (cfg),
    .selValid (selValid),
    .selAddr  (selAddr),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdData   (rdData)
  );

endmodule

// File: tb/hsk_port_tb.sv
`timescale 1ns/1ps
module hsk_port_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic selValid, selWrite;
  logic [1:0] selAddr;
  logic [W-1:0] wrData, rdData, pinIn, pinOut, pinOe;
  logic c1In, c2In, c2Out, c2Oe;
  logic [1:0] flagClr;
  logic c1Flag, c2Flag, c1Set, c2Set;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [W-1:0] lastRd;

  always #4 clk = ~clk;

  hsk_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .selValid(selValid), .selWrite(selWrite),
    .selAddr(selAddr), .wrData(wrData), .rdData(rdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .c1In(c1In), .c2In(c2In),
    .c2Out(c2Out), .c2Oe(c2Oe), .flagClr(flagClr), .c1Flag(c1Flag),
    .c2Flag(c2Flag), .c1Set(c1Set), .c2Set(c2Set)
  );

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] mOut = '0, mDir = '0, mLat = '0;
  logic [4:0]   mCtl = '0;
  bit mC1p = 0, mC2p = 0, mF1 = 0, mF2 = 0, mS1 = 0, mS2 = 0, mHs = 1;

  function automatic bit edgeHit(bit prev, bit cur, bit rise);
    return rise ? (cur && !prev) : (!cur && prev);
  endfunction

  function automatic logic [W-1:0] mRead();
    logic [W-1:0] v;
    if (!selValid) return '0;
    case (selAddr)
      2'd1:    v = mDir;
      2'd3:    v = {3'b000, mCtl};
      default: for (int i = 0; i < W; i++)
                 v[i] = mDir[i] ? mOut[i] : (mCtl[4] ? mLat[i] : pinIn[i]);
    endcase
    return v;
  endfunction

  function automatic bit mC2Out();
    if (mCtl[3:1] == 3'b110) return 1'b0;
    if (mCtl[3:1] == 3'b111) return 1'b1;
    return mHs;
  endfunction

  always @(posedge clk) begin
    bit h1, h2, hs;
    int mode;
    if (!rstN) begin
      mOut = '0; mDir = '0; mLat = '0; mCtl = '0;
      mC1p = 0; mC2p = 0; mF1 = 0; mF2 = 0; mS1 = 0; mS2 = 0; mHs = 1;
    end else begin
      mode = int'(mCtl[3:1]);
      h1 = edgeHit(mC1p, c1In, mCtl[0]);
      h2 = (mode < 4) && edgeHit(mC2p, c2In, mCtl[2]);
      hs = selValid && (selAddr == 2'd0);
      if (h1) mF1 = 1; else if (hs || flagClr[0]) mF1 = 0;
      if (h2) mF2 = 1;
      else if (flagClr[1] || (hs && mode < 4 && (mode % 2) == 0)) mF2 = 0;
      mS1 = h1; mS2 = h2;
      if (mode == 4) begin
        if (hs) mHs = 0; else if (h1) mHs = 1;
      end else if (mode == 5) mHs = !hs;
      else mHs = 1;
      if (mCtl[4] && h1) mLat = pinIn;
      if (selValid && selWrite) begin
        case (selAddr)
          2'd1:    mDir = wrData;
          2'd3:    mCtl = wrData[4:0];
          default: mOut = wrData;
        endcase
      end
      mC1p = c1In; mC2p = c2In;
    end
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN === 1'b1 && !finished) begin
      chk("R1 pinOut", pinOut, mOut);
      chk("R1 pinOe", pinOe, mDir);
      chk("R1 R7 rdData", rdData, mRead());
      chk("R2 c1Flag", c1Flag, mF1);
      chk("R2 c1Set", c1Set, mS1);
      chk("R3 R9 c2Flag", c2Flag, mF2);
      chk("R3 c2Set", c2Set, mS2);
      chk("R4 R5 R6 c2Out", c2Out, mC2Out());
      chk("R6 c2Oe", c2Oe, mCtl[3]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic acc(bit w, logic [1:0] a, logic [W-1:0] d);
    selValid = 1; selWrite = w; selAddr = a; wrData = d;
    #1 lastRd = rdData;
    @(posedge clk); #2;
    selValid = 0; selWrite = 0;
  endtask

  task automatic setC1(bit v); c1In = v; step(); endtask
  task automatic setC2(bit v); c2In = v; step(); endtask
  task automatic clr(logic [1:0] m); flagClr = m; step(); flagClr = 2'b00; endtask

  task automatic finish();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    rstN = 0; selValid = 0; selWrite = 0; selAddr = 0; wrData = 0;
    pinIn = 0; c1In = 0; c2In = 0; flagClr = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;

    // R10 reset state
    chk("R10 pinOe", pinOe, 0);
    chk("R10 c2Oe", c2Oe, 0);
    chk("R10 c1Flag", c1Flag, 0);
    acc(0, 2'd3, 0);
    chk("R10 control readback", lastRd, 0);

    // R1 direction and readback
    acc(1, 2'd1, 8'hF0);
    acc(1, 2'd0, 8'hA5);
    pinIn = 8'h3C;
    acc(0, 2'd0, 0);
    chk("R1 mixed read", lastRd, 8'hAC);
    chk("R1 pinOe", pinOe, 8'hF0);
    chk("R1 pinOut", pinOut, 8'hA5);

    // R2 falling edge default
    setC1(1);
    chk("R2 wrong edge ignored", c1Flag, 0);
    setC1(0);
    chk("R2 falling sets flag", c1Flag, 1);
    chk("R2 set pulse", c1Set, 1);
    step();
    chk("R2 pulse one cycle", c1Set, 0);
    acc(0, 2'd2, 0);
    chk("R8 alias keeps flag", c1Flag, 1);
    acc(0, 2'd0, 0);
    chk("R9 access clears c1Flag", c1Flag, 0);

    // R2 rising polarity, R9 clear strobe
    acc(1, 2'd3, 8'h01);
    setC1(1);
    chk("R2 rising sets flag", c1Flag, 1);
    clr(2'b01);
    chk("R9 clear strobe c1", c1Flag, 0);
    setC1(0);
    chk("R2 falling ignored in rise mode", c1Flag, 0);

    // R3 line-two input modes
    acc(1, 2'd3, 8'h05);            // mode 010
    setC2(1);
    chk("R3 rising input", c2Flag, 1);
    acc(0, 2'd0, 0);
    chk("R9 access clears c2 input flag", c2Flag, 0);
    acc(1, 2'd3, 8'h07);            // mode 011
    setC2(0);
    chk("R3 indep rise ignores fall", c2Flag, 0);
    setC2(1);
    chk("R3 indep rising", c2Flag, 1);
    acc(0, 2'd0, 0);
    chk("R9 indep flag survives access", c2Flag, 1);
    clr(2'b10);
    chk("R9 clear strobe c2", c2Flag, 0);
    acc(1, 2'd3, 8'h03);            // mode 001
    setC2(0);
    chk("R3 indep falling", c2Flag, 1);
    clr(2'b10);
    acc(1, 2'd3, 8'h01);            // mode 000
    setC2(1);
    setC2(0);
    chk("R3 falling input", c2Flag, 1);
    acc(0, 2'd0, 0);
    chk("R9 access clears mode000 flag", c2Flag, 0);

    // R6 fixed levels, no flag in output modes
    acc(1, 2'd3, 8'h0D);            // mode 110
    setC2(1);
    setC2(0);
    chk("R3 output mode no flag", c2Flag, 0);
    chk("R6 drive low", c2Out, 0);
    chk("R6 oe in output mode", c2Oe, 1);
    acc(1, 2'd3, 8'h0F);            // mode 111
    chk("R6 drive high", c2Out, 1);

    // R4 handshake, line-one rising (c1In currently 0)
    acc(1, 2'd3, 8'h09);
    chk("R4 idle high", c2Out, 1);
    acc(0, 2'd0, 0);
    chk("R4 low after read access", c2Out, 0);
    acc(0, 2'd2, 0);
    chk("R8 alias no release", c2Out, 0);
    step();
    chk("R4 holds low", c2Out, 0);
    setC1(1);
    chk("R4 released by c1 edge", c2Out, 1);
    acc(1, 2'd0, 8'h11);
    chk("R4 low after write access", c2Out, 0);
    setC1(0);
    chk("R4 wrong edge keeps low", c2Out, 0);
    setC1(1);
    chk("R4 released again", c2Out, 1);

    // R5 pulse
    acc(1, 2'd3, 8'h0B);
    acc(0, 2'd0, 0);
    chk("R5 pulse low", c2Out, 0);
    step();
    chk("R5 pulse one cycle", c2Out, 1);
    acc(1, 2'd2, 8'h22);
    chk("R8 alias no pulse", c2Out, 1);

    // R7 input latch (c1In currently 1)
    acc(1, 2'd1, 8'h00);
    acc(1, 2'd3, 8'h11);
    setC1(0);
    pinIn = 8'h5A;
    setC1(1);
    pinIn = 8'hFF;
    acc(0, 2'd2, 0);
    chk("R7 latched value", lastRd, 8'h5A);
    setC1(0);
    acc(0, 2'd2, 0);
    chk("R7 held on wrong edge", lastRd, 8'h5A);
    setC1(1);
    acc(0, 2'd2, 0);
    chk("R7 recapture", lastRd, 8'hFF);

    // R9 set beats clear
    clr(2'b01);
    chk("R9 cleared before race", c1Flag, 0);
    c1In = 0; step();
    c1In = 1; flagClr = 2'b01; step(); flagClr = 2'b00;
    chk("R9 set wins over clear", c1Flag, 1);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      selValid = ($urandom_range(0, 9) < 3);
      selWrite = $urandom_range(0, 1);
      selAddr  = 2'($urandom_range(0, 3));
      wrData   = 8'($urandom);
      pinIn    = 8'($urandom);
      if ($urandom_range(0, 3) == 0) c1In = ~c1In;
      if ($urandom_range(0, 3) == 0) c2In = ~c2In;
      flagClr  = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      step();
    end
    selValid = 0; flagClr = 0;
    step();
    finish();
  end

endmodule